// File: doc/BRIEF.md
# SAR Converter Serial Port Target Model

This block is a synthesizable, device-side model of the digital serial port of a successive-approximation converter. It runs in the three-wire chip-select mode, with no busy indicator. It gives a host controller a protocol-accurate target to talk to. The block does no analog conversion. A parallel sample word stands in for the conversion result.

The host raises CNV to start a conversion. At that moment the model captures the word on `sample_i` and releases SDO. It then runs a conversion timer of `CONV_MAX` system clocks. The timer runs to the end no matter what CNV does.

After the conversion, the model waits with CNV high. When CNV goes low, it drives the most significant bit on SDO. Each later SCK falling edge moves SDO to the next lower bit. SDO is released after the last bit, or earlier if CNV rises.

CNV may drop briefly early in a conversion. If CNV is low while the timer count lies between `CONV_MIN` and `CONV_MAX-1`, that breaks the mode, and the model sets a sticky error flag.

Top module: `sar_serial_port`

## Requirements
- R1: While reset is asserted, and right after it, `sdo_oe_o`, `sdo_o` and `proto_err_o` are 0.
- R2: A CNV rising edge that arrives while no conversion runs starts a conversion. It captures `sample_i` and forces `sdo_oe_o` to 0.
- R3: A conversion lasts exactly `CONV_MAX` system clocks. Changes on CNV during a conversion, including a new rising edge, neither restart it nor end it. `sdo_oe_o` stays 0 throughout.
- R4: The captured word is held until the next conversion starts. Changes on `sample_i` at other times have no effect on the serial data.
- R5: When CNV is low after a conversion has ended, `sdo_oe_o` becomes 1 and `sdo_o` shows bit 13 (the MSB) of the captured word.
- R6: Each SCK falling edge during readout moves `sdo_o` to the next lower bit. An SCK rising edge changes nothing.
- R7: The 14th SCK falling edge sets `sdo_oe_o` to 0. Further SCK edges leave it at 0 until a new conversion has completed.
- R8: A CNV rising edge during readout sets `sdo_oe_o` to 0 at once and starts a new conversion.
- R9: `proto_err_o` is set when CNV is low in any clock whose conversion count lies in [`CONV_MIN`, `CONV_MAX-1`]. CNV low at a lower count does not set it.
- R10: `proto_err_o` stays 1 until reset.
- R11: `sdo_o` is 0 whenever `sdo_oe_o` is 0.
- R12: CNV and SCK are sampled by `clk_i`. An input change shows at the outputs two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_i | input | DATA_W | Parallel word that stands in for the conversion result |
| cnv_i | input | 1 | Convert / chip-select line from the host |
| sck_i | input | 1 | Serial clock from the host |
| sdo_o | output | 1 | Serial data, MSB first |
| sdo_oe_o | output | 1 | Output enable for SDO; 0 means high impedance |
| proto_err_o | output | 1 | Sticky flag for a CNV-low protocol violation |

## Verification
The hardest case to reach is a second CNV rising edge inside a running conversion that must not restart the timer. The stimulus drops CNV a few clocks after the start and raises it again well before `CONV_MIN`. It then lowers CNV just after the end of the original conversion. If the second edge had restarted the timer, that low would fall inside the violation window. The bench would then see the error flag set and no data. The correct result is a clean MSB and no error. The violation window is reached separately, with CNV dropped a few counts above `CONV_MIN`.

// File: rtl/sarport_pkg.sv
package sarport_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_CONV = 2'd1,
    PS_WAIT = 2'd2,
    PS_READ = 2'd3
  } port_state_e;

endpackage

// File: rtl/sarport_edge_det.sv
module sarport_edge_det #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] smp_q;
  logic [N-1:0] prv_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        smp_q[g] <= 1'b0;
        prv_q[g] <= 1'b0;
      end else begin
        smp_q[g] <= in_i[g];
        prv_q[g] <= smp_q[g];
      end
    end

    assign lvl_o[g]  = smp_q[g];
    assign rise_o[g] = smp_q[g] & ~prv_q[g];
    assign fall_o[g] = ~smp_q[g] & prv_q[g];
  end

endmodule

// File: rtl/sarport_conv_timer.sv
module sarport_conv_timer #(
  parameter int CONV_MIN = 20,
  parameter int CONV_MAX = 32,
  localparam int CW = $clog2(CONV_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cnv_lvl_i,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          busy_q, busy_d;
  logic          err_q, err_d;
  logic          last_cnt;
  logic          in_window;

  assign last_cnt  = busy_q && (cnt_q == CW'(CONV_MAX - 1));
  assign in_window = busy_q && (cnt_q >= CW'(CONV_MIN));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (busy_q) begin
      cnt_en = 1'b1;
      if (last_cnt) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_en = 1'b1;
      cnt_d  = '0;
    end
  end

  always_comb begin
    err_d = err_q | (in_window & ~cnv_lvl_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = last_cnt;
  assign err_o  = err_q;

  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_cnt) |=> busy_q);

  // R3
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_cnt |=> !busy_q);

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  // R9
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(in_window && !cnv_lvl_i));

endmodule

// File: rtl/sarport_shifter.sv
module sarport_shifter #(
  parameter int DATA_W = 14,
  localparam int IW = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              load_i,
  input  logic              shift_i,
  output logic              sdo_o,
  output logic              oe_o,
  output logic              last_o
);

  logic [DATA_W-1:0] word_q, word_d;
  logic              word_en;
  logic [IW-1:0]     idx_q, idx_d;
  logic              idx_en;
  logic              oe_q, oe_d;
  logic              step;

  assign step   = shift_i && oe_q;
  assign last_o = step && (idx_q == '0);

  always_comb begin
    word_en = capture_i;
    word_d  = sample_i;
  end

  always_comb begin
    idx_en = 1'b0;
    idx_d  = idx_q;
    oe_d   = oe_q;
    if (capture_i) begin
      oe_d   = 1'b0;
      idx_en = 1'b1;
      idx_d  = IW'(DATA_W - 1);
    end else if (load_i) begin
      oe_d   = 1'b1;
      idx_en = 1'b1;
      idx_d  = IW'(DATA_W - 1);
    end else if (step) begin
      if (idx_q == '0) begin
        oe_d = 1'b0;
      end else begin
        idx_en = 1'b1;
        idx_d  = idx_q - IW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= IW'(DATA_W - 1);
      oe_q   <= 1'b0;
    end else begin
      oe_q <= oe_d;
      if (word_en) begin
        word_q <= word_d;
      end
      if (idx_en) begin
        idx_q <= idx_d;
      end
    end
  end

  assign sdo_o = oe_q & word_q[idx_q];
  assign oe_o  = oe_q;

  // R4
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(word_q));

  // R6
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && !load_i && !shift_i) |=> $stable(idx_q));

  // R7
  oe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_q) |-> ($past(capture_i) || $past(last_o)));

endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sarport_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int CONV_MIN = 20,
  parameter int CONV_MAX = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              cnv_i,
  input  logic              sck_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              proto_err_o
);

  localparam int LN_CNV = 0;
  localparam int LN_SCK = 1;

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic [1:0]  ln_lvl, ln_rise, ln_fall;
  logic        cnv_lvl, cnv_rise, sck_rise, sck_fall;
  logic        tmr_busy, tmr_done, tmr_err;
  logic        start, load, shift, last_bit;
  port_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  sarport_edge_det #(.N(2)) edge_i (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .in_i   ({sck_i, cnv_i}),
    .lvl_o  (ln_lvl),
    .rise_o (ln_rise),
    .fall_o (ln_fall)
  );

  assign cnv_lvl  = ln_lvl[LN_CNV];
  assign cnv_rise = ln_rise[LN_CNV];
  assign sck_rise = ln_rise[LN_SCK];
  assign sck_fall = ln_fall[LN_SCK];

  assign start = cnv_rise && (state_q != PS_CONV);
  assign load  = (state_q == PS_WAIT) && !cnv_lvl;
  assign shift = (state_q == PS_READ) && sck_fall && !start;

  sarport_conv_timer #(
    .CONV_MIN (CONV_MIN),
    .CONV_MAX (CONV_MAX)
  ) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .start_i   (start),
    .cnv_lvl_i (cnv_lvl),
    .busy_o    (tmr_busy),
    .done_o    (tmr_done),
    .err_o     (tmr_err)
  );

  sarport_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .capture_i (start),
    .sample_i  (sample_i),
    .load_i    (load),
    .shift_i   (shift),
    .sdo_o     (sdo_o),
    .oe_o      (sdo_oe_o),
    .last_o    (last_bit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE: if (start) state_d = PS_CONV;
      PS_CONV: if (tmr_done) state_d = PS_WAIT;
      PS_WAIT: begin
        if (start)     state_d = PS_CONV;
        else if (load) state_d = PS_READ;
      end
      PS_READ: begin
        if (start)         state_d = PS_CONV;
        else if (last_bit) state_d = PS_IDLE;
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= PS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign proto_err_o = tmr_err;

  // R3
  conv_no_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (state_q == PS_CONV) |-> !sdo_oe_o);

  // R3
  conv_track_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (state_q == PS_CONV) |-> tmr_busy);

  // R5
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $rose(sdo_oe_o) |-> ($past(state_q == PS_WAIT) && $past(!cnv_lvl)));

  // R6
  rise_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (sck_rise && (state_q == PS_READ) && !start) |=> ($stable(sdo_o) && $stable(sdo_oe_o)));

  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (cnv_rise && (state_q == PS_READ)) |=> (!sdo_oe_o && (state_q == PS_CONV)));

endmodule

// File: tb/sar_serial_port_tb.sv
module sar_serial_port_tb_top;

  localparam int DW   = 14;
  localparam int CMIN = 20;
  localparam int CMAX = 32;

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] sample;
  logic          cnv;
  logic          sck;
  logic          sdo;
  logic          oe;
  logic          err;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  sar_serial_port #(.DATA_W(DW), .CONV_MIN(CMIN), .CONV_MAX(CMAX)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sample_i    (sample),
    .cnv_i       (cnv),
    .sck_i       (sck),
    .sdo_o       (sdo),
    .sdo_oe_o    (oe),
    .proto_err_o (err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulse();
    sck = 1'b1;
    tick(2);
    sck = 1'b0;
    tick(2);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cnv = 1'b0;
    sck = 1'b0;
    tick(3);
    check("R1", "oe in reset", oe, 0);
    check("R1", "sdo in reset", sdo, 0);
    check("R1", "err in reset", err, 0);
    rst_n = 1'b1;
    tick(4);
    check("R1", "oe after reset", oe, 0);
    check("R1", "err after reset", err, 0);
  endtask

  // raise CNV with a word, change sample_i after capture, wait past conversion end
  task automatic convert(input logic [DW-1:0] w);
    sample = w;
    cnv = 1'b1;
    tick(2);
    sample = ~w;
    check("R2", "oe at conversion start", oe, 0);
    tick(CMAX + 2);
    check("R3", "oe after conversion, CNV high", oe, 0);
  endtask

  task automatic open_read(input logic [DW-1:0] w);
    cnv = 1'b0;
    tick(1);
    check("R12", "oe one clock after CNV low", oe, 0);
    tick(1);
    check("R5", "oe after CNV low", oe, 1);
    check("R5", "msb", sdo, int'(w[DW-1]));
  endtask

  task automatic shift_rest(input logic [DW-1:0] w);
    for (int i = DW - 2; i >= 0; i--) begin
      sck_pulse();
      check("R6", $sformatf("bit %0d", i), sdo, int'(w[i]));
    end
    sck_pulse();
    check("R7", "oe after last fall", oe, 0);
    check("R11", "sdo while released", sdo, 0);
    check("R9", "no error on clean frame", err, 0);
  endtask

  task automatic t_basic();
    logic [DW-1:0] w;
    w = 14'h2A5C;
    convert(w);
    open_read(w);
    shift_rest(w);
    sck_pulse();
    sck_pulse();
    check("R7", "oe after extra SCK", oe, 0);
  endtask

  task automatic t_patterns();
    logic [DW-1:0] pats [3];
    pats[0] = 14'h1555;
    pats[1] = 14'h2AAA;
    pats[2] = 14'h0001;
    for (int p = 0; p < 3; p++) begin
      convert(pats[p]);
      open_read(pats[p]);
      shift_rest(pats[p]);
    end
  endtask

  task automatic t_sck_rise();
    logic [DW-1:0] w;
    w = 14'h2001;
    convert(w);
    open_read(w);
    sck = 1'b1;
    tick(3);
    check("R6", "sdo after SCK rise", sdo, int'(w[DW-1]));
    sck = 1'b0;
    tick(2);
    check("R6", "bit 12 after fall", sdo, int'(w[DW-2]));
    shift_rest_from(w, DW - 3);
  endtask

  task automatic shift_rest_from(input logic [DW-1:0] w, input int top);
    for (int i = top; i >= 0; i--) begin
      sck_pulse();
      check("R6", $sformatf("bit %0d", i), sdo, int'(w[i]));
    end
    sck_pulse();
    check("R7", "oe after last fall", oe, 0);
  endtask

  task automatic t_abort();
    logic [DW-1:0] w1, w2;
    w1 = 14'h3C3C;
    w2 = 14'h0F0F;
    convert(w1);
    open_read(w1);
    sck_pulse();
    sck_pulse();
    sck_pulse();
    check("R6", "bit 10 before abort", sdo, int'(w1[10]));
    sample = w2;
    cnv = 1'b1;
    tick(2);
    check("R8", "oe after CNV rise in readout", oe, 0);
    check("R11", "sdo after abort", sdo, 0);
    sample = 14'h1234;
    sck_pulse();
    check("R8", "oe with SCK during new conversion", oe, 0);
    tick(CMAX);
    open_read(w2);
    shift_rest(w2);
  endtask

  task automatic t_ignored_rise();
    logic [DW-1:0] w;
    w = 14'h2B17;
    sample = w;
    cnv = 1'b1;
    tick(4);
    cnv = 1'b0;
    tick(2);
    check("R3", "oe with CNV low in conversion", oe, 0);
    sample = 14'h0C3A;
    cnv = 1'b1;
    tick(4);
    tick(CMAX - 6);
    open_read(w);
    check("R3", "no restart, no error", err, 0);
    check("R9", "low below minimum no error", err, 0);
    check("R4", "word kept, bit 13", sdo, int'(w[13]));
    shift_rest(w);
  endtask

  task automatic t_violation();
    logic [DW-1:0] w;
    w = 14'h0AAA;
    do_reset();
    sample = w;
    cnv = 1'b1;
    tick(CMIN + 5);
    check("R9", "err before low", err, 0);
    cnv = 1'b0;
    tick(3);
    check("R9", "err after low in window", err, 1);
    cnv = 1'b1;
    tick(CMAX + 4);
    convert(14'h1111);
    open_read(14'h1111);
    check("R10", "err still set", err, 1);
    do_reset();
    check("R10", "err cleared by reset", err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sample = '0;
    cnv = 1'b0;
    sck = 1'b0;
    do_reset();
    t_basic();
    t_patterns();
    t_sck_rise();
    t_abort();
    t_ignored_rise();
    t_violation();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule